// File: doc/BRIEF.md
# Searchable Hazard Queue

An in-order queue placed between an instruction fetch/decode stage and an execute stage. Each slot holds one decoded instruction: a 2-bit kind, a destination register name and an opaque payload. Execute reads the oldest slot, then dequeues it, or flushes every slot when a branch is taken. Fetch pushes newly decoded entries at the tail.

The block also answers a question for fetch: will any in-flight entry still write a given register? One search port serves an arbitrary register name. Two more searches are fed from the source registers of the raw instruction waiting in fetch, and these drive a per-kind stall output. In a single cycle the block applies its operations in this order: head read, then dequeue or flush, then search, then enqueue. A search therefore never sees the slot leaving this cycle, the slots being flushed, or the entry arriving this cycle. Operand fetch, arithmetic, memory access and branch resolution stay outside the block.

Top module: `hazard_sfifo`

## Requirements
- R1: After reset the queue is empty: head_valid_o, full_o, overflow_o, search_hit_o and stall_o are all 0.
- R2: Entries leave in enqueue order. While head_valid_o is 1, head_kind_o, head_dst_o and head_payload_o show the oldest entry. The head is unchanged in any cycle without a dequeue or a flush.
- R3: An enqueue while full_o is 1, with no dequeue and no flush in the same cycle, is dropped. overflow_o is 1 in that cycle and 0 in every other cycle. full_o is 1 exactly when DEPTH entries are held.
- R4: A dequeue while the queue is empty has no effect.
- R5: search_hit_o is 1 when some held entry has kind add (2'd0) or load (2'd2) and a destination equal to search_reg_i. Entries of kind branch-if-zero (2'd1) and store (2'd3) never match.
- R6: In a cycle with a dequeue on a non-empty queue, the head entry is excluded from every search.
- R7: In a flush cycle no entry matches, so search_hit_o and stall_o are 0. The entry being enqueued in the current cycle is never visible to a search in that cycle.
- R8: clear_i empties the queue by the next cycle. It overrides a dequeue in the same cycle, and an enqueue in the same cycle is dropped.
- R9: With inst_valid_i at 1, an add (2'd0) or branch-if-zero (2'd1) instruction stalls when inst_src_a_i or inst_src_b_i matches. For branch-if-zero these are the condition and target-address registers.
- R10: A load (2'd2) stalls only when inst_src_b_i (its address register) matches; inst_src_a_i is ignored. A store (2'd3) stalls when inst_src_a_i (value) or inst_src_b_i (address) matches. stall_o is 0 when inst_valid_i is 0.
- R11: On a full queue, a dequeue and an enqueue in the same cycle both take effect. The queue stays full and the new entry becomes the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Push an entry |
| enq_kind_i | input | 2 | Kind of pushed entry |
| enq_dst_i | input | REG_W | Destination register of pushed entry |
| enq_payload_i | input | PAYLOAD_W | Opaque payload of pushed entry |
| deq_i | input | 1 | Pop the head entry |
| clear_i | input | 1 | Flush all entries |
| head_valid_o | output | 1 | Head entry present |
| head_kind_o | output | 2 | Head kind |
| head_dst_o | output | REG_W | Head destination register |
| head_payload_o | output | PAYLOAD_W | Head payload |
| full_o | output | 1 | All slots occupied |
| overflow_o | output | 1 | Push dropped because full |
| search_reg_i | input | REG_W | Register name to search |
| search_hit_o | output | 1 | A live writer of search_reg_i exists |
| inst_valid_i | input | 1 | Raw instruction present in fetch |
| inst_kind_i | input | 2 | Raw instruction kind |
| inst_src_a_i | input | REG_W | First source register (add src, bz cond, store value) |
| inst_src_b_i | input | REG_W | Second source register (add src, bz target, load/store address) |
| stall_o | output | 1 | Raw instruction must wait |

## Verification
Directed sequences probe the queue when it is empty, full and wrapping. They then pair each search with a same-cycle dequeue, flush or enqueue of the matching entry. This separates a search that applies the cycle ordering from one that reads the registered state. Entries of every kind share destination names, which shows whether non-writing kinds are kept out of matches. Raw loads whose first source collides check that the per-kind stall rule drops that operand. A long random stream of all four kinds, over a small register range and with occasional taken-branch flushes, is compared every cycle against a reference queue.

// File: rtl/hsb_pkg.sv
`timescale 1ns/1ps
package hsb_pkg;
  typedef enum logic [1:0] {
    KIND_ADD   = 2'd0,
    KIND_BZ    = 2'd1,
    KIND_LOAD  = 2'd2,
    KIND_STORE = 2'd3
  } kind_e;

  // only add and load produce a register result
  function automatic logic kind_writes_reg(kind_e k);
    return (k == KIND_ADD) || (k == KIND_LOAD);
  endfunction
endpackage

// File: rtl/hsb_slots.sv
`timescale 1ns/1ps
module hsb_slots #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned PAYLOAD_W = 32,
  localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            push_i,
  input  logic [1:0]                      push_kind_i,
  input  logic [REG_W-1:0]                push_dst_i,
  input  logic [PAYLOAD_W-1:0]            push_payload_i,
  input  logic                            pop_i,
  input  logic                            flush_i,
  output logic [DEPTH-1:0]                valid_o,
  output logic [DEPTH-1:0][1:0]           kind_o,
  output logic [DEPTH-1:0][REG_W-1:0]     dst_o,
  output logic [PTR_W-1:0]                head_idx_o,
  output logic [PAYLOAD_W-1:0]            head_payload_o,
  output logic                            full_o,
  output logic                            empty_o
);
  logic [DEPTH-1:0]                valid_q;
  logic [DEPTH-1:0][1:0]           kind_q;
  logic [DEPTH-1:0][REG_W-1:0]     dst_q;
  logic [DEPTH-1:0][PAYLOAD_W-1:0] pay_q;
  logic [PTR_W-1:0]                wr_ptr_q, rd_ptr_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      valid_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (pop_i) begin
        valid_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q          <= ptr_inc(rd_ptr_q);
      end
      // on a full swap the push slot equals the pop slot; set wins
      if (push_i) begin
        valid_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q          <= ptr_inc(wr_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      kind_q[wr_ptr_q] <= push_kind_i;
      dst_q[wr_ptr_q]  <= push_dst_i;
      pay_q[wr_ptr_q]  <= push_payload_i;
    end
  end

  assign valid_o        = valid_q;
  assign kind_o         = kind_q;
  assign dst_o          = dst_q;
  assign head_idx_o     = rd_ptr_q;
  assign head_payload_o = pay_q[rd_ptr_q];
  assign full_o         = valid_q[wr_ptr_q];
  assign empty_o        = ~valid_q[rd_ptr_q];
endmodule

// File: rtl/hsb_search.sv
`timescale 1ns/1ps
module hsb_search
  import hsb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5
) (
  input  logic [DEPTH-1:0]            live_i,
  input  logic [DEPTH-1:0][1:0]       kind_i,
  input  logic [DEPTH-1:0][REG_W-1:0] dst_i,
  input  logic [REG_W-1:0]            query_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] slot_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_hit[g] = live_i[g] & kind_writes_reg(kind_e'(kind_i[g])) & (dst_i[g] == query_i);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/hsb_stall.sv
`timescale 1ns/1ps
module hsb_stall
  import hsb_pkg::*;
(
  input  logic       inst_valid_i,
  input  logic [1:0] inst_kind_i,
  input  logic       hit_a_i,
  input  logic       hit_b_i,
  output logic       stall_o
);
  always_comb begin
    unique case (kind_e'(inst_kind_i))
      KIND_LOAD: stall_o = hit_b_i;            // address only
      default:   stall_o = hit_a_i | hit_b_i;  // add, bz, store
    endcase
    stall_o = stall_o & inst_valid_i;
  end
endmodule

// File: rtl/hazard_sfifo.sv
`timescale 1ns/1ps
module hazard_sfifo #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned PAYLOAD_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_valid_i,
  input  logic [1:0]           enq_kind_i,
  input  logic [REG_W-1:0]     enq_dst_i,
  input  logic [PAYLOAD_W-1:0] enq_payload_i,
  input  logic                 deq_i,
  input  logic                 clear_i,
  output logic                 head_valid_o,
  output logic [1:0]           head_kind_o,
  output logic [REG_W-1:0]     head_dst_o,
  output logic [PAYLOAD_W-1:0] head_payload_o,
  output logic                 full_o,
  output logic                 overflow_o,
  input  logic [REG_W-1:0]     search_reg_i,
  output logic                 search_hit_o,
  input  logic                 inst_valid_i,
  input  logic [1:0]           inst_kind_i,
  input  logic [REG_W-1:0]     inst_src_a_i,
  input  logic [REG_W-1:0]     inst_src_b_i,
  output logic                 stall_o
);
  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned N_QUERY = 3;

  logic [DEPTH-1:0]            valid;
  logic [DEPTH-1:0][1:0]       kind;
  logic [DEPTH-1:0][REG_W-1:0] dst;
  logic [PTR_W-1:0]            head_idx;
  logic                        full, empty;
  logic                        deq_fire, enq_fire;
  logic [DEPTH-1:0]            pop_mask, live;
  logic [N_QUERY-1:0][REG_W-1:0] query;
  logic [N_QUERY-1:0]          hit;

  // cycle order: first -> deq/clear -> search -> enq
  assign deq_fire   = deq_i & ~empty & ~clear_i;
  assign enq_fire   = enq_valid_i & ~clear_i & (~full | deq_fire);
  assign overflow_o = enq_valid_i & ~clear_i & full & ~deq_fire;

  hsb_slots #(
    .DEPTH(DEPTH), .REG_W(REG_W), .PAYLOAD_W(PAYLOAD_W)
  ) u_slots (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .push_i         (enq_fire),
    .push_kind_i    (enq_kind_i),
    .push_dst_i     (enq_dst_i),
    .push_payload_i (enq_payload_i),
    .pop_i          (deq_fire),
    .flush_i        (clear_i),
    .valid_o        (valid),
    .kind_o         (kind),
    .dst_o          (dst),
    .head_idx_o     (head_idx),
    .head_payload_o (head_payload_o),
    .full_o         (full),
    .empty_o        (empty)
  );

  always_comb begin
    pop_mask = '0;
    if (deq_fire) pop_mask[head_idx] = 1'b1;
  end

  assign live  = clear_i ? '0 : (valid & ~pop_mask);
  assign query = {inst_src_b_i, inst_src_a_i, search_reg_i};

  for (genvar q = 0; q < N_QUERY; q++) begin : g_query
    hsb_search #(.DEPTH(DEPTH), .REG_W(REG_W)) u_search (
      .live_i  (live),
      .kind_i  (kind),
      .dst_i   (dst),
      .query_i (query[q]),
      .hit_o   (hit[q])
    );
  end

  hsb_stall u_stall (
    .inst_valid_i (inst_valid_i),
    .inst_kind_i  (inst_kind_i),
    .hit_a_i      (hit[1]),
    .hit_b_i      (hit[2]),
    .stall_o      (stall_o)
  );

  assign search_hit_o = hit[0];
  assign head_valid_o = ~empty;
  assign head_kind_o  = kind[head_idx];
  assign head_dst_o   = dst[head_idx];
  assign full_o       = full;
endmodule

// File: rtl/hsb_checker.sv
`timescale 1ns/1ps
module hsb_checker #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             deq_i,
  input logic             clear_i,
  input logic             head_valid_o,
  input logic [REG_W-1:0] head_dst_o,
  input logic             full_o,
  input logic             overflow_o,
  input logic             search_hit_o,
  input logic             stall_o
);
  p_head_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_valid_o && !deq_i && !clear_i) |=> (head_valid_o && $stable(head_dst_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (full_o && enq_valid_i));

  p_ovf_keeps_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> full_o);

  p_deq_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!head_valid_o && deq_i && !enq_valid_i) |=> !head_valid_o);

  p_empty_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_o |-> (!search_hit_o && !stall_o));

  p_clear_no_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (!search_hit_o && !stall_o));

  p_clear_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!head_valid_o && !full_o));

  p_full_swap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && deq_i && enq_valid_i && !clear_i) |=> full_o);
endmodule

bind hazard_sfifo hsb_checker #(.REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enq_valid_i  (enq_valid_i),
  .deq_i        (deq_i),
  .clear_i      (clear_i),
  .head_valid_o (head_valid_o),
  .head_dst_o   (head_dst_o),
  .full_o       (full_o),
  .overflow_o   (overflow_o),
  .search_hit_o (search_hit_o),
  .stall_o      (stall_o)
);

// File: tb/hazard_sfifo_tb_top.sv
`timescale 1ns/1ps
module hazard_sfifo_tb_top;
  localparam int DEPTH = 4;
  localparam int REG_W = 5;
  localparam int PW    = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic enq_valid, deq, clr, head_valid, full, ovf, hit, inst_valid, stall;
  logic [1:0] enq_kind, head_kind, inst_kind;
  logic [REG_W-1:0] enq_dst, head_dst, sreg, src_a, src_b;
  logic [PW-1:0] enq_pay, head_pay;

  hazard_sfifo #(.DEPTH(DEPTH), .REG_W(REG_W), .PAYLOAD_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_kind_i(enq_kind), .enq_dst_i(enq_dst), .enq_payload_i(enq_pay),
    .deq_i(deq), .clear_i(clr),
    .head_valid_o(head_valid), .head_kind_o(head_kind), .head_dst_o(head_dst), .head_payload_o(head_pay),
    .full_o(full), .overflow_o(ovf),
    .search_reg_i(sreg), .search_hit_o(hit),
    .inst_valid_i(inst_valid), .inst_kind_i(inst_kind), .inst_src_a_i(src_a), .inst_src_b_i(src_b),
    .stall_o(stall)
  );

  typedef struct {
    logic [1:0]       kind;
    logic [REG_W-1:0] dst;
    logic [PW-1:0]    pay;
  } ent_t;

  ent_t model[$];   // expected contents, oldest first
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit q_hit(ent_t q[$], logic [REG_W-1:0] r);
    foreach (q[i]) if ((q[i].kind == 2'd0 || q[i].kind == 2'd2) && q[i].dst == r) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drive_idle();
    enq_valid = 0; enq_kind = 0; enq_dst = 0; enq_pay = 0; deq = 0; clr = 0;
    sreg = 0; inst_valid = 0; inst_kind = 0; src_a = 0; src_b = 0;
  endtask

  // driver + monitor for one cycle; model holds expected items
  task automatic step(bit ev, logic [1:0] k, logic [REG_W-1:0] d, logic [PW-1:0] p,
                      bit dq, bit cl, logic [REG_W-1:0] sr,
                      bit iv, logic [1:0] ik, logic [REG_W-1:0] sa, logic [REG_W-1:0] sb);
    ent_t live[$];
    ent_t ne;
    bit exp_hit, exp_stall, exp_ovf;
    string tag;
    @(negedge clk);
    enq_valid = ev; enq_kind = k; enq_dst = d; enq_pay = p; deq = dq; clr = cl;
    sreg = sr; inst_valid = iv; inst_kind = ik; src_a = sa; src_b = sb;
    #1;
    chk("R2", "head_valid", 64'(head_valid), 64'(model.size() > 0));
    if (model.size() > 0) begin
      chk("R2", "head_kind", 64'(head_kind), 64'(model[0].kind));
      chk("R2", "head_dst", 64'(head_dst), 64'(model[0].dst));
      chk("R2", "head_payload", 64'(head_pay), 64'(model[0].pay));
    end
    chk("R3", "full", 64'(full), 64'(model.size() == DEPTH));
    live = model;
    if (cl) live.delete();
    else if (dq && live.size() > 0) void'(live.pop_front());
    exp_hit = q_hit(live, sr);
    tag = (cl || (ev && sr == d)) ? "R7" : (dq ? "R6" : "R5");
    chk(tag, "search_hit", 64'(hit), 64'(exp_hit));
    exp_stall = iv && ((ik == 2'd2) ? q_hit(live, sb) : (q_hit(live, sa) || q_hit(live, sb)));
    chk(ik[1] ? "R10" : "R9", "stall", 64'(stall), 64'(exp_stall));
    exp_ovf = ev && !cl && (live.size() == DEPTH);
    chk("R3", "overflow", 64'(ovf), 64'(exp_ovf));
    @(posedge clk);
    model = live;
    if (ev && !cl && live.size() < DEPTH) begin
      ne.kind = k; ne.dst = d; ne.pay = p;
      model.push_back(ne);
    end
    #1;
    drive_idle();
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    inst_valid = 1; inst_kind = 2'd0;
    repeat (3) @(posedge clk);
    sample();
    chk("R1", "head_valid", 64'(head_valid), 64'd0);
    chk("R1", "full", 64'(full), 64'd0);
    chk("R1", "overflow", 64'(ovf), 64'd0);
    chk("R1", "search_hit", 64'(hit), 64'd0);
    chk("R1", "stall", 64'(stall), 64'd0);
    rst_n = 1'b1;
    drive_idle();

    // R4: pop on empty
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    sample();
    chk("R4", "head_valid after empty deq", 64'(head_valid), 64'd0);
    chk("R4", "full after empty deq", 64'(full), 64'd0);

    // fill with adds to r1..r4, searching each
    for (int i = 1; i <= DEPTH; i++)
      step(1, 2'd0, REG_W'(i), PW'(32'hA0 + i), 0, 0, REG_W'(i - 1), 1, 2'd0, REG_W'(i - 1), 5'd0);
    // R3: push on full, then state unchanged
    step(1, 2'd2, 5'd20, 32'hBAD, 0, 0, 5'd20, 1, 2'd2, 5'd0, 5'd20);
    sample();
    chk("R3", "head_dst after overflow", 64'(head_dst), 64'd1);
    chk("R3", "full after overflow", 64'(full), 64'd1);

    // R11: swap on full; R6: head r1 hidden from search
    step(1, 2'd2, 5'd9, 32'hC9, 1, 0, 5'd1, 1, 2'd0, 5'd1, 5'd1);
    sample();
    chk("R11", "full after swap", 64'(full), 64'd1);
    chk("R11", "head_dst after swap", 64'(head_dst), 64'd2);

    // R10: load ignores src_a (r3 live), checks src_b
    step(0, 0, 0, 0, 0, 0, 5'd3, 1, 2'd2, 5'd3, 5'd30);
    step(0, 0, 0, 0, 0, 0, 5'd9, 1, 2'd2, 5'd30, 5'd9);
    step(0, 0, 0, 0, 0, 0, 5'd4, 1, 2'd3, 5'd4, 5'd30);

    // drain, then store/bz writers never match (R5)
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 0, 5'd2, 1, 2'd1, 5'd3, 5'd9);
    step(1, 2'd3, 5'd7, 32'h57, 0, 0, 5'd0, 0, 0, 0, 0);
    step(1, 2'd1, 5'd8, 32'h58, 0, 0, 5'd7, 1, 2'd3, 5'd7, 5'd8);
    step(0, 0, 0, 0, 0, 0, 5'd8, 1, 2'd1, 5'd8, 5'd7);
    // R7: entry arriving this cycle not visible
    step(1, 2'd0, 5'd12, 32'h5C, 0, 0, 5'd12, 1, 2'd0, 5'd12, 5'd12);
    step(0, 0, 0, 0, 0, 0, 5'd12, 1, 2'd0, 5'd12, 5'd0);
    // R8: flush with deq and enq
    step(1, 2'd0, 5'd13, 32'h5D, 1, 1, 5'd12, 1, 2'd0, 5'd12, 5'd13);
    sample();
    chk("R8", "head_valid after clear", 64'(head_valid), 64'd0);
    chk("R8", "full after clear", 64'(full), 64'd0);
    chk("R8", "dropped entry not found", 64'(hit), 64'd0);

    // random stream of all four kinds with taken branches
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 6, 2'($urandom), REG_W'($urandom % 8), PW'($urandom),
           ($urandom % 2) == 1, ($urandom % 20) == 0, REG_W'($urandom % 8),
           ($urandom % 4) != 0, 2'($urandom), REG_W'($urandom % 8), REG_W'($urandom % 8));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule